// File: doc/BRIEF.md
# PWM Timebase and Compare Event Stage

This block is the counting and comparison front end of one PWM generator. It divides the system clock (or passes it through), runs a counter against a period value, and reports what the counter is doing as a set of single-cycle event strobes. These are a direction flag, a zero-reached strobe, a period-reached strobe, and match strobes for two compare channels. A later waveform stage is expected to turn these strobes into output levels. That stage is not part of this block.

The counter has two modes. In descending mode it falls from the period value to zero and reloads, which suits edge-aligned waveforms. In triangle mode it climbs from zero to the period value and falls back, which suits centre-aligned waveforms. In triangle mode each compare match is reported on a separate up or down strobe according to the counting direction. A compare value above the period value can never match. All strobes are qualified by the prescaler tick, so each one lasts exactly one system clock, in the cycle where the counter leaves the reported value. The block has no streaming data path. All pins are plain control and status levels, with no valid/ready handshake.

Top module: `pwm_timebase`

## Requirements
- R1: While `rst_n` is low and `enable` is low, `count` is 0, every event strobe is low, and `dir` equals `updown`.
- R2: With `updown`=0, the counter value seen at tick k (k=0 is the first tick after reset) is 0 for k=0, and `load_val` - ((k-1) mod (`load_val`+1)) after that.
- R3: With `updown`=1 and `load_val`=L>0, let p = k mod 2L. The counter value at tick k is p when p<=L, and 2L-p otherwise. With L=0 the counter holds 0.
- R4: `dir` is 0 throughout descending mode. In triangle mode `dir` is 1 (up) when p<L or L=0, and 0 (down) otherwise.
- R5: `zero_evt` is high for exactly the tick cycles in which `count` is 0.
- R6: `load_evt` is high for exactly the tick cycles in which `count` equals `load_val`.
- R7: In descending mode, the tick after a `zero_evt` carries a `load_evt`.
- R8: A compare channel pulses in a tick cycle where `count` equals its compare value. The pulse goes on `*_up_evt` when `dir`=1 and on `*_dn_evt` when `dir`=0.
- R9: A compare channel whose value exceeds `load_val` never pulses.
- R10: In descending mode both `*_up_evt` outputs stay low.
- R11: With `use_div`=0 the counter advances on every clock cycle in which `enable` is high.
- R12: With `use_div`=1 a tick occurs once every 2^min(`div_sel`+1,6) clocks of `enable`, on the last clock of each group. Every strobe is high only in that tick cycle.
- R13: While `enable` is low, `count` holds its value and every event strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable; low freezes the counter and clears the divider |
| updown | input | 1 | 0 = descending mode, 1 = triangle mode |
| use_div | input | 1 | 1 = count on divided ticks, 0 = count on every clock |
| div_sel | input | DIV_SEL_W | Divider exponent code; divisor is 2^min(code+1,6) |
| load_val | input | CNT_W | Period value |
| cmpa_val | input | CNT_W | Compare value, channel A |
| cmpb_val | input | CNT_W | Compare value, channel B |
| count | output | CNT_W | Present counter value |
| dir | output | 1 | Counting direction, 1 = up |
| zero_evt | output | 1 | Counter-at-zero strobe |
| load_evt | output | 1 | Counter-at-period strobe |
| cmpa_up_evt | output | 1 | Channel A match while counting up |
| cmpa_dn_evt | output | 1 | Channel A match while counting down |
| cmpb_up_evt | output | 1 | Channel B match while counting up |
| cmpb_dn_evt | output | 1 | Channel B match while counting down |

## Verification
The bench builds the block with a 6-bit counter and the default 3-bit divider code. The narrow counter makes the full-scale period of 63 cheap to cover, so both modes run over two complete periods with every compare value from 0 up to one past the period. The 3-bit code covers every divisor, including the two codes that clamp to 64. Expected count, direction and strobes come from closed-form expressions in the tick index.

// File: rtl/pwm_timebase_pkg.sv
package pwm_timebase_pkg;

  typedef enum logic {
    CNT_DOWN   = 1'b0,
    CNT_UPDOWN = 1'b1
  } cnt_mode_e;

  localparam int unsigned NUM_CMP = 2;

  // Divider exponent for a select code, clamped to the largest supported shift.
  function automatic int unsigned div_shift(input int unsigned code, input int unsigned max_log2);
    int unsigned s;
    s = code + 1;
    if (s > max_log2) s = max_log2;
    return s;
  endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int unsigned SEL_W    = 3,
  parameter int unsigned MAX_LOG2 = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             use_div,
  input  logic [SEL_W-1:0] div_sel,
  output logic             tick
);
  import pwm_timebase_pkg::*;

  localparam int unsigned CW = MAX_LOG2;

  logic [CW-1:0] div_cnt;
  logic [CW-1:0] div_lim;
  int unsigned   shift;

  always_comb begin
    shift   = div_shift(int'(div_sel), MAX_LOG2);
    div_lim = CW'((1 << shift) - 1);
  end

  // Bypass: every enabled clock is a tick. Divided: last clock of each group.
  assign tick = enable & (~use_div | (div_cnt >= div_lim));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
    end else if (!enable || !use_div || tick) begin
      div_cnt <= '0;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/pwm_updown_counter.sv
module pwm_updown_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tick,
  input  pwm_timebase_pkg::cnt_mode_e mode,
  input  logic [CNT_W-1:0]            load_val,
  output logic [CNT_W-1:0]            count,
  output logic                        dir_up
);
  import pwm_timebase_pkg::*;

  logic [CNT_W-1:0] cnt_n;
  logic             dir_n;

  always_comb begin
    cnt_n = count;
    dir_n = dir_up;
    if (mode == CNT_DOWN) begin
      // Descending: reload from the period value after zero.
      dir_n = 1'b1;
      cnt_n = (count == '0) ? load_val : count - 1'b1;
    end else if (dir_up) begin
      if (count < load_val) begin
        cnt_n = count + 1'b1;
        dir_n = (cnt_n != load_val);   // arriving at the top turns downward
      end else begin
        cnt_n = (count == '0) ? '0 : count - 1'b1;
        dir_n = (cnt_n == '0);
      end
    end else begin
      if (count == '0) begin
        dir_n = 1'b1;
      end else begin
        cnt_n = count - 1'b1;
        dir_n = (cnt_n == '0);         // arriving at zero turns upward
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      dir_up <= 1'b1;
    end else if (tick) begin
      count  <= cnt_n;
      dir_up <= dir_n;
    end
  end

endmodule

// File: rtl/pwm_cmp_unit.sv
module pwm_cmp_unit #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             tick,
  input  logic             dir,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] cmp_val,
  output logic             up_evt,
  output logic             dn_evt
);
  logic reachable;
  logic hit;

  assign reachable = (cmp_val <= load_val);
  assign hit       = tick & reachable & (count == cmp_val);
  assign up_evt    = hit & dir;
  assign dn_evt    = hit & ~dir;

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned DIV_SEL_W = 3,
  parameter int unsigned DIV_MAX_LOG2 = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 updown,
  input  logic                 use_div,
  input  logic [DIV_SEL_W-1:0] div_sel,
  input  logic [CNT_W-1:0]     load_val,
  input  logic [CNT_W-1:0]     cmpa_val,
  input  logic [CNT_W-1:0]     cmpb_val,
  output logic [CNT_W-1:0]     count,
  output logic                 dir,
  output logic                 zero_evt,
  output logic                 load_evt,
  output logic                 cmpa_up_evt,
  output logic                 cmpa_dn_evt,
  output logic                 cmpb_up_evt,
  output logic                 cmpb_dn_evt
);
  import pwm_timebase_pkg::*;

  cnt_mode_e        mode;
  logic             tick;
  logic             dir_up;
  logic [NUM_CMP-1:0][CNT_W-1:0] cmp_vals;
  logic [NUM_CMP-1:0] up_vec;
  logic [NUM_CMP-1:0] dn_vec;

  assign mode = cnt_mode_e'(updown);

  pwm_prescaler #(
    .SEL_W    (DIV_SEL_W),
    .MAX_LOG2 (DIV_MAX_LOG2)
  ) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .use_div (use_div),
    .div_sel (div_sel),
    .tick    (tick)
  );

  pwm_updown_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .mode     (mode),
    .load_val (load_val),
    .count    (count),
    .dir_up   (dir_up)
  );

  assign dir      = (mode == CNT_UPDOWN) & dir_up;
  assign zero_evt = tick & (count == '0);
  assign load_evt = tick & (count == load_val);

  assign cmp_vals[0] = cmpa_val;
  assign cmp_vals[1] = cmpb_val;

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    pwm_cmp_unit #(
      .CNT_W (CNT_W)
    ) u_cmp (
      .tick     (tick),
      .dir      (dir),
      .count    (count),
      .load_val (load_val),
      .cmp_val  (cmp_vals[g]),
      .up_evt   (up_vec[g]),
      .dn_evt   (dn_vec[g])
    );
  end

  assign cmpa_up_evt = up_vec[0];
  assign cmpa_dn_evt = dn_vec[0];
  assign cmpb_up_evt = up_vec[1];
  assign cmpb_dn_evt = dn_vec[1];

endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             updown,
  input logic [CNT_W-1:0] load_val,
  input logic [CNT_W-1:0] cmpa_val,
  input logic [CNT_W-1:0] cmpb_val,
  input logic [CNT_W-1:0] count,
  input logic             dir,
  input logic             zero_evt,
  input logic             load_evt,
  input logic             cmpa_up_evt,
  input logic             cmpa_dn_evt,
  input logic             cmpb_up_evt,
  input logic             cmpb_dn_evt
);

  AST_DIR_LOW_DESC: assert property (@(posedge clk) disable iff (!rst_n)
    !updown |-> !dir); // R4

  AST_NO_UP_IN_DESC: assert property (@(posedge clk) disable iff (!rst_n)
    !updown |-> (!cmpa_up_evt && !cmpb_up_evt)); // R10

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !(zero_evt || load_evt || cmpa_up_evt || cmpa_dn_evt || cmpb_up_evt || cmpb_dn_evt)); // R13

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(count)); // R13

  AST_ZERO_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |-> (count == '0)); // R5

  AST_LOAD_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |-> (count == load_val)); // R6

  AST_RELOAD_AFTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!updown && zero_evt) |=> (count == $past(load_val))); // R7

  AST_A_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpa_up_evt || cmpa_dn_evt) |-> (cmpa_val <= load_val)); // R9

  AST_B_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpb_up_evt || cmpb_dn_evt) |-> (cmpb_val <= load_val)); // R9

  AST_SPLIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmpa_up_evt, cmpa_dn_evt}) && $onehot0({cmpb_up_evt, cmpb_dn_evt})); // R8

endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .updown      (updown),
  .load_val    (load_val),
  .cmpa_val    (cmpa_val),
  .cmpb_val    (cmpb_val),
  .count       (count),
  .dir         (dir),
  .zero_evt    (zero_evt),
  .load_evt    (load_evt),
  .cmpa_up_evt (cmpa_up_evt),
  .cmpa_dn_evt (cmpa_dn_evt),
  .cmpb_up_evt (cmpb_up_evt),
  .cmpb_dn_evt (cmpb_dn_evt)
);

// File: tb/tb_pwm_timebase.sv
module tb_pwm_timebase;
  localparam int CLK_PERIOD = 10;
  localparam int W    = 6;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         enable = 1'b0;
  logic         updown = 1'b0;
  logic         use_div = 1'b0;
  logic [2:0]   div_sel = '0;
  logic [W-1:0] load_val = '0;
  logic [W-1:0] cmpa_val = '0;
  logic [W-1:0] cmpb_val = '0;
  logic [W-1:0] count;
  logic dir, zero_evt, load_evt, cmpa_up_evt, cmpa_dn_evt, cmpb_up_evt, cmpb_dn_evt;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_timebase #(.CNT_W(W), .DIV_SEL_W(3), .DIV_MAX_LOG2(6)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .updown(updown), .use_div(use_div),
    .div_sel(div_sel), .load_val(load_val), .cmpa_val(cmpa_val), .cmpb_val(cmpb_val),
    .count(count), .dir(dir), .zero_evt(zero_evt), .load_evt(load_evt),
    .cmpa_up_evt(cmpa_up_evt), .cmpa_dn_evt(cmpa_dn_evt),
    .cmpb_up_evt(cmpb_up_evt), .cmpb_dn_evt(cmpb_dn_evt)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_cnt(input bit m, input int l, input int k);
    int p;
    if (!m) return (k == 0) ? 0 : l - ((k - 1) % (l + 1));
    if (l == 0) return 0;
    p = k % (2 * l);
    return (p <= l) ? p : 2 * l - p;
  endfunction

  function automatic bit exp_dir(input bit m, input int l, input int k);
    if (!m) return 1'b0;
    if (l == 0) return 1'b1;
    return (k % (2 * l)) < l;
  endfunction

  task automatic chk_cmp(input bit m, input int l, input int cv, input bit tk, input int ec,
                         input bit ed, input bit up_a, input bit dn_a, input string ch);
    bit hit;
    string tag;
    hit = tk && (cv <= l) && (ec == cv);
    tag = (cv > l) ? "R9" : (!m ? "R10" : "R8");
    check(up_a == (hit && ed), {tag, " up ", ch}, up_a, hit && ed);
    check(dn_a == (hit && !ed), {tag, " dn ", ch}, dn_a, hit && !ed);
  endtask

  // Sample all outputs in the current cycle against the closed-form model.
  task automatic check_cycle(input bit m, input int l, input int ca, input int cb,
                             input bit tk, input int k, input string ctag);
    int ec;
    bit ed;
    ec = exp_cnt(m, l, k);
    ed = exp_dir(m, l, k);
    check(int'(count) == ec, ctag, count, ec);
    check(dir == ed, "R4", dir, ed);
    check(zero_evt == (tk && ec == 0), "R5", zero_evt, tk && ec == 0);
    check(load_evt == (tk && ec == l), "R6", load_evt, tk && ec == l);
    chk_cmp(m, l, ca, tk, ec, ed, cmpa_up_evt, cmpa_dn_evt, "A");
    chk_cmp(m, l, cb, tk, ec, ed, cmpb_up_evt, cmpb_dn_evt, "B");
  endtask

  task automatic start(input bit m, input int l, input int ca, input int cb,
                       input bit ud, input int sel);
    rst_n = 1'b0; enable = 1'b0;
    updown = m; use_div = ud; div_sel = 3'(sel);
    load_val = W'(l); cmpa_val = W'(ca); cmpb_val = W'(cb);
    @(negedge clk);
    #1;
    check(count == '0, "R1 count", count, 0);
    check(dir == m, "R1 dir", dir, m);
    check(!(zero_evt || load_evt || cmpa_up_evt || cmpa_dn_evt || cmpb_up_evt || cmpb_dn_evt),
          "R1 events", 1, 0);
    @(negedge clk);
    rst_n = 1'b1; enable = 1'b1;
  endtask

  task automatic run_cfg(input bit m, input int l, input int ca, input int cb,
                         input bit ud, input int sel);
    int n, shift, ticks, prev;
    bit prev_zero;
    string ctag;
    start(m, l, ca, cb, ud, sel);
    shift = (sel + 1 > 6) ? 6 : sel + 1;
    n     = ud ? (1 << shift) : 1;
    ticks = 2 * (2 * l + 2) + 3;
    ctag  = ud ? "R12" : (m ? "R3" : "R2");
    prev = -1;
    prev_zero = 1'b0;
    for (int c = 0; c < ticks * n; c++) begin
      bit tk;
      int k;
      #1;
      tk = ((c % n) == n - 1);
      k  = c / n;
      check_cycle(m, l, ca, cb, tk, k, ctag);
      if (!ud && l > 0 && c > 0) check(int'(count) != prev, "R11", count, prev);
      if (!ud && !m && prev_zero) check(load_evt == 1'b1, "R7", load_evt, 1);
      prev = int'(count);
      prev_zero = zero_evt;
      @(negedge clk);
    end
  endtask

  task automatic run_freeze();
    int ec;
    start(1'b1, 5, 2, 4, 1'b0, 0);
    for (int c = 0; c < 7; c++) begin
      #1; check_cycle(1'b1, 5, 2, 4, 1'b1, c, "R3"); @(negedge clk);
    end
    enable = 1'b0;
    ec = exp_cnt(1'b1, 5, 7);
    for (int c = 0; c < 6; c++) begin
      #1;
      check(int'(count) == ec, "R13 hold", count, ec);
      check(!(zero_evt || load_evt || cmpa_up_evt || cmpa_dn_evt || cmpb_up_evt || cmpb_dn_evt),
            "R13 quiet", 1, 0);
      @(negedge clk);
    end
    enable = 1'b1;
    for (int c = 7; c < 20; c++) begin
      #1; check_cycle(1'b1, 5, 2, 4, 1'b1, c, "R13 resume"); @(negedge clk);
    end
  endtask

  initial begin
    int loads [5] = '{0, 1, 2, 5, 63};
    for (int mi = 0; mi < 2; mi++) begin
      foreach (loads[li]) begin
        int l, top;
        l = loads[li];
        top = (l + 1 > MAXV) ? MAXV : l + 1;
        for (int ca = 0; ca <= top; ca++) begin
          int cb;
          cb = (ca * 3 + 1) % (l + 2);
          if (cb > MAXV) cb = MAXV;
          run_cfg(mi[0], l, ca, cb, 1'b0, 0);
        end
      end
    end
    for (int mi = 0; mi < 2; mi++)
      for (int s = 0; s < 8; s++)
        run_cfg(mi[0], 3, 1, 2, 1'b1, s);
    run_freeze();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule